// File: doc/BRIEF.md
# Register-Register Integer Execute Unit

This block is the purely combinational execute stage for register-to-register integer instructions of a RISC-V style core. It takes the 7-bit major opcode, the 3-bit minor function field and the 7-bit extended function field of the instruction. It also takes the two source operands, each `XLEN` bits wide. It returns the `XLEN`-bit result and a flag that says whether the encoding was recognised. The operation is chosen straight from the instruction fields. There is no abstract ALU op code between the decoder and this unit.

The base set covers addition, subtraction, the three bitwise operations and the signed and unsigned less-than tests. A parameter adds a multiply/divide option, which provides the low half of the product and the signed quotient. The two divide corner cases have fixed results, so the output never depends on simulator arithmetic. `XLEN` may be 32 or 64. No register, clock or reset sits inside the unit. A result is available in the same cycle as the operands.

Top module: `rr_int_alu`

## Requirements
- R1: With opcode 7'h33, funct3 0 and funct7 7'h00, valid is 1 and the result is src_a + src_b modulo 2^XLEN.
- R2: With opcode 7'h33, funct3 0 and funct7 7'h20, valid is 1 and the result is src_a - src_b modulo 2^XLEN.
- R3: With opcode 7'h33 and funct7 7'h00, funct3 7 gives src_a AND src_b, funct3 6 gives OR and funct3 4 gives XOR, each with valid 1.
- R4: With opcode 7'h33, funct3 2 and funct7 7'h00, the result is 1 when src_a is less than src_b as two's-complement numbers and 0 otherwise, zero-extended to XLEN bits.
- R5: With opcode 7'h33, funct3 3 and funct7 7'h00, the result is 1 when src_a is less than src_b as unsigned numbers and 0 otherwise, zero-extended to XLEN bits.
- R6: When MULDIV_EN is 1, opcode 7'h33 with funct3 0 and funct7 7'h01 gives the low XLEN bits of src_a * src_b, with valid 1.
- R7: When MULDIV_EN is 1, opcode 7'h33 with funct3 4 and funct7 7'h01 gives the signed quotient src_a / src_b, truncated toward zero, with valid 1.
- R8: A signed divide with src_b equal to zero returns all ones, with valid 1.
- R9: A signed divide of the most negative value (only the top bit set) by all ones returns src_a unchanged, with valid 1.
- R10: Any encoding not listed in R1 to R7 drives valid to 0 and the result to zero. This covers any opcode other than 7'h33, any other funct7, funct7 7'h20 with funct3 other than 0, and funct7 7'h01 with funct3 other than 0 or 4.
- R11: When MULDIV_EN is 0, every encoding with funct7 7'h01 drives valid to 0 and the result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 7 | Major opcode field of the instruction |
| funct3_i | input | 3 | Minor function field |
| funct7_i | input | 7 | Extended function field |
| src_a_i | input | XLEN | First source operand |
| src_b_i | input | XLEN | Second source operand |
| result_o | output | XLEN | Operation result, zero when valid_o is 0 |
| valid_o | output | 1 | High when the encoding is recognised |

## Verification
Two pairs of operations share a minor function code and are told apart only by the extended field. Addition shares code 0 with multiplication, and exclusive-or shares code 4 with division. The bench drives both encodings of each pair back to back with the same operands. A wrong funct7 comparison then shows up as the other operation's value. A second instance, built without the multiply/divide option, sees the same encoding on the same clock. Its output is judged in that cycle against the reference model: a full result from one instance and a zero result with the flag low from the other.

// File: rtl/rr_alu_pkg.sv
package rr_alu_pkg;

    localparam logic [6:0] OPC_REGREG = 7'h33;
    localparam logic [6:0] F7_PLAIN   = 7'h00;
    localparam logic [6:0] F7_NEGATE  = 7'h20;
    localparam logic [6:0] F7_MULDIV  = 7'h01;

    localparam logic [2:0] F3_ADDSUB  = 3'd0;
    localparam logic [2:0] F3_LTS     = 3'd2;
    localparam logic [2:0] F3_LTU     = 3'd3;
    localparam logic [2:0] F3_XOR     = 3'd4;
    localparam logic [2:0] F3_OR      = 3'd6;
    localparam logic [2:0] F3_AND     = 3'd7;
    localparam logic [2:0] F3_MULLO   = 3'd0;
    localparam logic [2:0] F3_DIVS    = 3'd4;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_ADD,
        OP_SUB,
        OP_AND,
        OP_OR,
        OP_XOR,
        OP_LTS,
        OP_LTU,
        OP_MULLO,
        OP_DIVS
    } alu_op_e;

    typedef struct packed {
        logic    valid;
        alu_op_e op;
    } alu_dec_t;

    function automatic alu_op_e base_op(input logic [2:0] f3);
        case (f3)
            F3_ADDSUB: return OP_ADD;
            F3_LTS:    return OP_LTS;
            F3_LTU:    return OP_LTU;
            F3_XOR:    return OP_XOR;
            F3_OR:     return OP_OR;
            F3_AND:    return OP_AND;
            default:   return OP_NONE;
        endcase
    endfunction

    function automatic alu_op_e muldiv_op(input logic [2:0] f3);
        case (f3)
            F3_MULLO: return OP_MULLO;
            F3_DIVS:  return OP_DIVS;
            default:  return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rr_alu_decode.sv
module rr_alu_decode
    import rr_alu_pkg::*;
#(
    parameter bit MULDIV_EN = 1'b1
) (
    input  logic [6:0] opcode_i,
    input  logic [2:0] funct3_i,
    input  logic [6:0] funct7_i,
    output alu_dec_t   dec_o
);

    alu_op_e op_sel;

    always_comb begin
        op_sel = OP_NONE;
        if (opcode_i == OPC_REGREG) begin
            case (funct7_i)
                F7_PLAIN:  op_sel = base_op(funct3_i);
                F7_NEGATE: op_sel = (funct3_i == F3_ADDSUB) ? OP_SUB : OP_NONE;
                F7_MULDIV: op_sel = MULDIV_EN ? muldiv_op(funct3_i) : OP_NONE;
                default:   op_sel = OP_NONE;
            endcase
        end
    end

    assign dec_o.op    = op_sel;
    assign dec_o.valid = (op_sel != OP_NONE);

    // R11: the option being off must shut out the whole funct7 row
    always_comb begin
        if (!MULDIV_EN && funct7_i == F7_MULDIV)
            p_nomd_shut_r11: assert (!dec_o.valid)
                else $error("muldiv encoding decoded while disabled");
    end

endmodule

// File: rtl/rr_alu_base.sv
module rr_alu_base #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] add_o,
    output logic [XLEN-1:0] sub_o,
    output logic [XLEN-1:0] and_o,
    output logic [XLEN-1:0] or_o,
    output logic [XLEN-1:0] xor_o,
    output logic [XLEN-1:0] lts_o,
    output logic [XLEN-1:0] ltu_o
);

    localparam int PADW = XLEN - 1;

    logic lt_signed;
    logic lt_unsigned;

    assign add_o = a_i + b_i;
    assign sub_o = a_i - b_i;
    assign and_o = a_i & b_i;
    assign or_o  = a_i | b_i;
    assign xor_o = a_i ^ b_i;

    assign lt_signed   = $signed(a_i) < $signed(b_i);
    assign lt_unsigned = a_i < b_i;

    assign lts_o = {{PADW{1'b0}}, lt_signed};
    assign ltu_o = {{PADW{1'b0}}, lt_unsigned};

    // R4 R5: the compare outcome must agree with the sign-flipped unsigned view
    always_comb begin
        p_lts_via_bias_r4: assert (lt_signed ==
                ((a_i ^ {1'b1, {PADW{1'b0}}}) < (b_i ^ {1'b1, {PADW{1'b0}}})))
            else $error("signed compare disagrees with biased compare");
        p_ltu_order_r5: assert (!(lt_unsigned && (b_i < a_i)))
            else $error("unsigned compare not antisymmetric");
    end

endmodule

// File: rtl/rr_alu_muldiv.sv
module rr_alu_muldiv #(
    parameter int XLEN      = 32,
    parameter bit MULDIV_EN = 1'b1
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] mul_o,
    output logic [XLEN-1:0] div_o
);

    localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};
    localparam logic [XLEN-1:0] ALL_ONES = '1;

    generate
        if (MULDIV_EN) begin : g_muldiv
            logic div_by_zero;
            logic div_overflow;

            assign div_by_zero  = (b_i == '0);
            assign div_overflow = (a_i == MOST_NEG) && (b_i == ALL_ONES);

            assign mul_o = a_i * b_i;

            always_comb begin
                if (div_by_zero)
                    div_o = ALL_ONES;
                else if (div_overflow)
                    div_o = a_i;
                else
                    div_o = XLEN'($signed(a_i) / $signed(b_i));
            end

            // R7: a quotient of an ordinary divide never exceeds the dividend in size
            always_comb begin
                if (!div_by_zero && !div_overflow && a_i[XLEN-1] == 1'b0
                    && b_i[XLEN-1] == 1'b0)
                    p_div_bound_r7: assert (div_o <= a_i)
                        else $error("positive quotient larger than dividend");
            end
        end else begin : g_none
            assign mul_o = '0;
            assign div_o = '0;
        end
    endgenerate

endmodule

// File: rtl/rr_int_alu.sv
module rr_int_alu
    import rr_alu_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter bit MULDIV_EN = 1'b1
) (
    input  logic [6:0]      opcode_i,
    input  logic [2:0]      funct3_i,
    input  logic [6:0]      funct7_i,
    input  logic [XLEN-1:0] src_a_i,
    input  logic [XLEN-1:0] src_b_i,
    output logic [XLEN-1:0] result_o,
    output logic            valid_o
);

    localparam logic [XLEN-1:0] TOP_ONLY = {1'b1, {(XLEN-1){1'b0}}};

    alu_dec_t        dec;
    logic [XLEN-1:0] r_add, r_sub, r_and, r_or, r_xor, r_lts, r_ltu;
    logic [XLEN-1:0] r_mul, r_div;

    rr_alu_decode #(.MULDIV_EN(MULDIV_EN)) u_decode (
        .opcode_i (opcode_i),
        .funct3_i (funct3_i),
        .funct7_i (funct7_i),
        .dec_o    (dec)
    );

    rr_alu_base #(.XLEN(XLEN)) u_base (
        .a_i   (src_a_i),
        .b_i   (src_b_i),
        .add_o (r_add),
        .sub_o (r_sub),
        .and_o (r_and),
        .or_o  (r_or),
        .xor_o (r_xor),
        .lts_o (r_lts),
        .ltu_o (r_ltu)
    );

    rr_alu_muldiv #(.XLEN(XLEN), .MULDIV_EN(MULDIV_EN)) u_muldiv (
        .a_i   (src_a_i),
        .b_i   (src_b_i),
        .mul_o (r_mul),
        .div_o (r_div)
    );

    always_comb begin
        case (dec.op)
            OP_ADD:   result_o = r_add;
            OP_SUB:   result_o = r_sub;
            OP_AND:   result_o = r_and;
            OP_OR:    result_o = r_or;
            OP_XOR:   result_o = r_xor;
            OP_LTS:   result_o = r_lts;
            OP_LTU:   result_o = r_ltu;
            OP_MULLO: result_o = r_mul;
            OP_DIVS:  result_o = r_div;
            default:  result_o = '0;
        endcase
    end

    assign valid_o = dec.valid;

    always_comb begin
        // R1: the sum less the second operand gives back the first
        if (dec.op == OP_ADD)
            p_add_inverse_r1: assert (result_o - src_b_i == src_a_i)
                else $error("add result inconsistent");
        // R2: the difference plus the second operand gives back the first
        if (dec.op == OP_SUB)
            p_sub_inverse_r2: assert (result_o + src_b_i == src_a_i)
                else $error("sub result inconsistent");
        // R4: a less-than result has only the lowest bit free
        if (dec.op == OP_LTS || dec.op == OP_LTU)
            p_lt_zext_r4: assert (result_o[XLEN-1:1] == '0)
                else $error("compare result not zero-extended");
        // R8: divide by zero yields all ones
        if (dec.op == OP_DIVS && src_b_i == '0)
            p_divzero_ones_r8: assert (&result_o)
                else $error("divide by zero result wrong");
        // R9: overflow case returns the dividend
        if (dec.op == OP_DIVS && src_a_i == TOP_ONLY && &src_b_i)
            p_div_ovf_r9: assert (result_o == src_a_i)
                else $error("overflowing divide result wrong");
        // R10: an unrecognised encoding drives nothing
        if (!valid_o)
            p_invalid_zero_r10: assert (result_o == '0)
                else $error("result nonzero with valid low");
    end

endmodule

// File: tb/test_rr_int_alu.sv
module test_rr_int_alu;

    localparam int XLEN = 32;
    localparam logic [XLEN-1:0] MIN_NEG = 32'h8000_0000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [6:0]      opcode = '0;
    logic [2:0]      funct3 = '0;
    logic [6:0]      funct7 = '0;
    logic [XLEN-1:0] src_a = '0;
    logic [XLEN-1:0] src_b = '0;
    logic [XLEN-1:0] res_md, res_nomd;
    logic            val_md, val_nomd;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    rr_int_alu #(.XLEN(XLEN), .MULDIV_EN(1'b1)) i_rr_int_alu (
        .opcode_i (opcode), .funct3_i (funct3), .funct7_i (funct7),
        .src_a_i  (src_a),  .src_b_i  (src_b),
        .result_o (res_md), .valid_o  (val_md)
    );

    rr_int_alu #(.XLEN(XLEN), .MULDIV_EN(1'b0)) i_rr_int_alu_nomd (
        .opcode_i (opcode), .funct3_i (funct3), .funct7_i (funct7),
        .src_a_i  (src_a),  .src_b_i  (src_b),
        .result_o (res_nomd), .valid_o (val_nomd)
    );

    // behavioural reference, straight from the requirements
    function automatic logic [XLEN:0] model(input logic [6:0] op, input logic [2:0] f3,
                                            input logic [6:0] f7, input logic [XLEN-1:0] a,
                                            input logic [XLEN-1:0] b, input bit md);
        longint sa, sb, q;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        if (op != 7'h33) return '0;
        if (f7 == 7'h00 && f3 == 3'd0) return {1'b1, a + b};
        if (f7 == 7'h20 && f3 == 3'd0) return {1'b1, a - b};
        if (f7 == 7'h00 && f3 == 3'd7) return {1'b1, a & b};
        if (f7 == 7'h00 && f3 == 3'd6) return {1'b1, a | b};
        if (f7 == 7'h00 && f3 == 3'd4) return {1'b1, a ^ b};
        if (f7 == 7'h00 && f3 == 3'd2) return {1'b1, XLEN'(sa < sb ? 1 : 0)};
        if (f7 == 7'h00 && f3 == 3'd3) return {1'b1, XLEN'(a < b ? 1 : 0)};
        if (md && f7 == 7'h01 && f3 == 3'd0) return {1'b1, XLEN'(longint'(a) * longint'(b))};
        if (md && f7 == 7'h01 && f3 == 3'd4) begin
            if (sb == 0) return {1'b1, {XLEN{1'b1}}};
            q = sa / sb;
            return {1'b1, XLEN'(q)};
        end
        return '0;
    endfunction

    task automatic judge(input string tag, input string which, input logic v,
                         input logic [XLEN-1:0] r, input logic [XLEN:0] exp);
        n_checks++;
        if (v !== exp[XLEN] || r !== exp[XLEN-1:0]) begin
            n_fail++;
            $display("FAIL %s [%s]: actual valid=%0b result=%h expected valid=%0b result=%h",
                     tag, which, v, r, exp[XLEN], exp[XLEN-1:0]);
        end
    endtask

    task automatic apply(input string tag, input logic [6:0] op, input logic [2:0] f3,
                         input logic [6:0] f7, input logic [XLEN-1:0] a,
                         input logic [XLEN-1:0] b);
        @(negedge clk);
        opcode = op; funct3 = f3; funct7 = f7; src_a = a; src_b = b;
        @(posedge clk);
        #1;
        judge(tag, "md", val_md, res_md, model(op, f3, f7, a, b, 1'b1));
        judge((op == 7'h33 && f7 == 7'h01) ? "R11" : tag, "nomd",
              val_nomd, res_nomd, model(op, f3, f7, a, b, 1'b0));
    endtask

    function automatic logic [31:0] xs(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        return t ^ (t << 5);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] seed;
        logic [6:0]  f7sel;
        seed = 32'h1234_5678;
        repeat (3) @(posedge clk);
        #1;
        judge("R10", "reset", val_md, res_md, '0);
        @(negedge clk);
        rst = 1'b0;

        apply("R1", 7'h33, 3'd0, 7'h00, 32'd5, 32'd7);
        apply("R1", 7'h33, 3'd0, 7'h00, 32'hFFFF_FFFF, 32'd1);
        apply("R2", 7'h33, 3'd0, 7'h20, 32'd3, 32'd5);
        apply("R2", 7'h33, 3'd0, 7'h20, 32'h0000_0000, 32'h8000_0000);
        apply("R3", 7'h33, 3'd7, 7'h00, 32'hF0F0_1234, 32'h0FF0_FF00);
        apply("R3", 7'h33, 3'd6, 7'h00, 32'hF0F0_1234, 32'h0FF0_FF00);
        apply("R3", 7'h33, 3'd4, 7'h00, 32'hF0F0_1234, 32'h0FF0_FF00);
        apply("R4", 7'h33, 3'd2, 7'h00, 32'hFFFF_FFFF, 32'd1);
        apply("R4", 7'h33, 3'd2, 7'h00, 32'd1, 32'hFFFF_FFFF);
        apply("R4", 7'h33, 3'd2, 7'h00, 32'd9, 32'd9);
        apply("R5", 7'h33, 3'd3, 7'h00, 32'd1, 32'hFFFF_FFFF);
        apply("R5", 7'h33, 3'd3, 7'h00, 32'hFFFF_FFFF, 32'd1);
        // shared funct3 pairs, same operands back to back
        apply("R1", 7'h33, 3'd0, 7'h00, 32'd7, 32'hFFFF_FFFD);
        apply("R6", 7'h33, 3'd0, 7'h01, 32'd7, 32'hFFFF_FFFD);
        apply("R6", 7'h33, 3'd0, 7'h01, 32'h0001_0000, 32'h0001_0000);
        apply("R6", 7'h33, 3'd0, 7'h01, 32'h1234_5678, 32'h9ABC_DEF1);
        apply("R3", 7'h33, 3'd4, 7'h00, 32'hFFFF_FFF9, 32'd2);
        apply("R7", 7'h33, 3'd4, 7'h01, 32'hFFFF_FFF9, 32'd2);
        apply("R7", 7'h33, 3'd4, 7'h01, 32'd7, 32'hFFFF_FFFE);
        apply("R7", 7'h33, 3'd4, 7'h01, 32'd100, 32'd7);
        apply("R8", 7'h33, 3'd4, 7'h01, 32'd123, 32'd0);
        apply("R8", 7'h33, 3'd4, 7'h01, 32'd0, 32'd0);
        apply("R9", 7'h33, 3'd4, 7'h01, MIN_NEG, 32'hFFFF_FFFF);
        apply("R10", 7'h13, 3'd0, 7'h00, 32'd5, 32'd7);
        apply("R10", 7'h33, 3'd7, 7'h20, 32'd5, 32'd7);
        apply("R10", 7'h33, 3'd1, 7'h00, 32'd5, 32'd7);
        apply("R10", 7'h33, 3'd5, 7'h00, 32'd5, 32'd7);
        apply("R10", 7'h33, 3'd1, 7'h01, 32'd5, 32'd7);
        apply("R10", 7'h33, 3'd0, 7'h02, 32'd5, 32'd7);

        for (int i = 0; i < 400; i++) begin
            logic [6:0]      op;
            logic [XLEN-1:0] a, b;
            seed = xs(seed);
            op = seed[3:2] == 2'b00 ? seed[14:8] : 7'h33;
            case (seed[5:4])
                2'd0: f7sel = 7'h00;
                2'd1: f7sel = 7'h20;
                2'd2: f7sel = 7'h01;
                default: f7sel = seed[22:16];
            endcase
            seed = xs(seed);
            a = seed;
            seed = xs(seed);
            b = seed[0] ? {{28{seed[1]}}, seed[5:2]} : seed;
            apply("R10", op, a[2:0], f7sel, a, b);
        end

        finish_run();
    end

endmodule